// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a serial-input digital-to-analog converter. A host drives three pins: an active-low frame select, a serial clock and a serial data line. While the frame select is low, each rising serial clock edge moves one data bit into a shift register, most significant bit first. When the frame select returns high, the shift register is copied into a parallel holding register. That register drives the converter code. A one-cycle update strobe marks each copy.

The block runs on a fast system clock. The three host pins pass through synchronizers and are oversampled. Edge detection on the synchronized pins produces the shift and load events. The shift register is exactly as wide as the resolution, so surplus leading bits in a long frame fall off the top. Only the last bits clocked in reach the holding register.

The code and the strobe are plain outputs with no back-pressure. A consumer cannot stall a transfer. The code holds its value until the next frame ends, and the strobe is informational only.

Top module: `serial_dac_loader`

## Requirements
- R1: While the frame select is low, each rising edge of the serial clock shifts exactly one bit, taken from the serial data line, into the shift register. The system clock must run at least four times the serial clock rate, with each serial clock phase lasting at least two system clocks.
- R2: While the frame select is high, serial clock edges leave the shift register unchanged. The held code also keeps its value.
- R3: The held code changes only as the result of a rising edge of the frame select, which copies the shift register into it.
- R4: Words are sent most significant bit first. For a frame of exactly RES bits, the first bit sent lands in code bit RES-1 and the last bit sent lands in code bit 0.
- R5: If a frame carries more than RES clocks, the earliest surplus bits are dropped. The code becomes the last RES bits clocked in.
- R6: With RES set to 14, a full 16-bit frame is accepted, and the code becomes the last 14 bits entered.
- R7: A frame may be delivered as two 8-bit bursts with a pause of the serial clock between them, all within one select-low period. The result is the same as a continuous 16-bit frame.
- R8: After reset, the code and the shift register are zero and the update strobe is low.
- R9: A select rising edge with no serial clocks in the frame still transfers the current shift register contents and still pulses the strobe.
- R10: Each transfer pulses the update strobe high for exactly one system clock. The strobe and the new code appear within four system clocks of the select rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial data from the host, asynchronous |
| code | output | RES | Held converter code |
| update | output | 1 | One-cycle strobe after each transfer |

## Verification
Assertions check three things on every cycle. The shift register moves only on a detected serial clock edge, and the newest bit enters at bit 0. The code changes only in the cycle after a detected load. The strobe never lasts two cycles. Other behaviours can only be shown by the bench's scenarios, because they depend on whole frames as seen at the pins: surplus bits dropping off, the 14-bit variant, split-byte frames, zero-clock frames, and immunity to clock edges while the select is high. The bench tracks an independent model of the bits sent, to check each of these.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  typedef struct packed {
    logic shift_en;
    logic load;
    logic sdi;
  } ser_evt_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ser_edge.sv
module ser_edge
  import dac_front_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     sel_s,
  input  logic     sdi_s,
  output ser_evt_t evt
);
  logic sclk_d, sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_s;
    end
  end

  always_comb begin
    evt.shift_en = sclk_s & ~sclk_d & ~sel_s;
    evt.load     = sel_s & ~sel_d;
    evt.sdi      = sdi_s;
  end

  assert_load_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt.load |=> !evt.load);
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           sdi,
  output logic [RES-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits <= '0;
    else if (shift_en) bits <= {bits[RES-2:0], sdi};
  end

  assert_shift_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bits));

  assert_newest_at_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (bits[0] == $past(sdi)));
endmodule

// File: rtl/code_hold.sv
module code_hold #(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [RES-1:0] din,
  output logic [RES-1:0] code,
  output logic           update
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      update <= 1'b0;
    end else begin
      update <= load;
      if (load) code <= din;
    end
  end

  assert_strobe_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
  import dac_front_pkg::*;
#(
  parameter int RES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_n,
  input  logic           sclk,
  input  logic           sdi,
  output logic [RES-1:0] code,
  output logic           update
);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] PIN_RST = 3'b100;

  logic [NPINS-1:0] pins_s;
  ser_evt_t         evt;
  logic [RES-1:0]   shreg;

  pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sel_n, sclk, sdi}), .dout(pins_s));

  ser_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[1]), .sel_s(pins_s[2]),
    .sdi_s(pins_s[0]), .evt(evt));

  ser_shift #(.RES(RES)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(evt.shift_en), .sdi(evt.sdi),
    .bits(shreg));

  code_hold #(.RES(RES)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(evt.load), .din(shreg),
    .code(code), .update(update));

  assert_code_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> $past(evt.load));

  assert_strobe_follows_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt.load |=> update);
endmodule

// File: tb/serial_dac_loader_test.sv
module serial_dac_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd16, 32'h0000A5C3},
    {8'd16, 32'h0000FFFF},
    {8'd16, 32'h00000000},
    {8'd20, 32'h000F1234},
    {8'd24, 32'h00C0BEEF},
    {8'd8,  32'h0000005A},
    {8'd1,  32'h00000001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [15:0] code16;
  logic [13:0] code14;
  logic upd16, upd14;
  logic [31:0] model = '0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_dac_loader #(.RES(16)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .code(code16), .update(upd16));

  serial_dac_loader #(.RES(14)) uut14 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .code(code14), .update(upd14));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit track);
    @(negedge clk); sdi = b;
    repeat (2) @(negedge clk); sclk = 1'b1;
    repeat (3) @(negedge clk); sclk = 1'b0;
    if (track) model = {model[30:0], b};
  endtask

  task automatic send_word(input int n, input logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i], 1'b1);
  endtask

  task automatic open_frame();
    @(negedge clk); sel_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_frame(input string tag);
    int c16, c14;
    repeat (3) @(negedge clk);
    sel_n = 1'b1;
    c16 = 0; c14 = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      c16 += int'(upd16);
      c14 += int'(upd14);
    end
    check(code16 == model[15:0], tag, {16'h0, code16}, {16'h0, model[15:0]});
    check(code14 == model[13:0], "R6", {18'h0, code14}, {18'h0, model[13:0]});
    check(c16 == 1, "R10 strobe count", c16, 1);
    check(c14 == 1, "R10 strobe count 14-bit", c14, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(code16 == 16'h0, "R8 code", {16'h0, code16}, 0);
    check(upd16 == 1'b0, "R8 strobe", {31'h0, upd16}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(code14 == 14'h0, "R8 code 14-bit", {18'h0, code14}, 0);
    check(upd14 == 1'b0, "R8 strobe 14-bit", {31'h0, upd14}, 0);

    // Vector table: R1, R4, R5 and R6 across frame lengths
    for (int v = 0; v < NVEC; v++) begin
      int n;
      string tag;
      n = int'(VEC[v][39:32]);
      tag = (n > 16) ? "R5 surplus" : ((n < 16) ? "R1 short" : "R4 msb first");
      open_frame();
      send_word(n, VEC[v][31:0]);
      close_frame(tag);
    end

    // R2: clocks while select high change nothing
    held = code16;
    for (int i = 0; i < 6; i++) send_bit(~model[0], 1'b0);
    repeat (4) @(negedge clk);
    check(code16 == held, "R2 code held", {16'h0, code16}, {16'h0, held});
    // R9: zero-clock frame transfers unchanged shift contents
    open_frame();
    close_frame("R9 R2 zero-clock");

    // R7: two bytes with a pause inside one frame
    open_frame();
    send_word(8, 32'h3C);
    repeat (12) @(negedge clk);
    send_word(8, 32'hD2);
    close_frame("R7 split bytes");
    check(code16 == 16'h3CD2, "R7 value", {16'h0, code16}, 32'h3CD2);

    // R8: reset mid-run clears code and shift register
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(code16 == 16'h0, "R8 mid reset", {16'h0, code16}, 0);
    rst_n = 1'b1;
    model = '0;
    repeat (3) @(negedge clk);
    open_frame();
    close_frame("R8 shift cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule